// File: doc/BRIEF.md
# E3 Overhead Octet Inserter

This block sits on the transmit side of an E3 framer that uses the G.832 frame structure. An upstream stage supplies the outbound byte stream. Each byte comes with a valid qualifier, a start-of-frame strobe and a code that marks the overhead position the byte occupies. The block replaces the trail-trace octet with one entry from a 16-entry trace store. It steps through that store across a 16-frame multiframe. It also XORs a programmable test mask into each of the two framing-alignment octets and into the error-monitor (BIP-8) octet. These masks let test equipment inject framing and parity errors on purpose. All other bytes pass through unchanged.

A small byte-wide register port loads the masks and the trace characters. The trace store normally holds a 15-character access-point identifier plus one more entry. Every register reads back one cycle after its address is presented. Mask values and the trace entry are sampled at each start of frame. A host write therefore never splits an overhead octet between an old value and a new one.

Top module: `e3_oh_inserter`

## Requirements
- R1: After reset, out_valid and out_sof are 0, and every mask register and trace entry reads back as 0x00.
- R2: A valid byte with in_pos = 1 (FA1 position) leaves the block one cycle later as the input byte XOR the FA1 mask (address 0x48).
- R3: A valid byte with in_pos = 2 (FA2 position) leaves XORed with its own FA2 mask (address 0x49), independent of the FA1 mask.
- R4: A valid byte with in_pos = 3 (error-monitor position) leaves XORed with the EM mask (address 0x4A).
- R5: The three mask registers at 0x48, 0x49 and 0x4A can be written and read back. The value appears on reg_rdata one cycle after reg_addr is presented.
- R6: The trace entries sit at addresses 0x50 to 0x5F, with entry k at 0x50+k, and each can be written and read back.
- R7: A valid byte with in_pos = 4 (trail-trace position) is replaced by trace entry (n mod 16), where n counts the start-of-frame strobes since reset, starting at 0. The index wraps from 15 to 0.
- R8: A byte with in_pos = 0 or 5..7 passes through unchanged with one cycle of latency. out_valid and out_sof follow in_valid and in_valid AND in_sof one cycle later.
- R9: A mask written in the middle of a frame does not affect the rest of that frame. It takes effect from the next start-of-frame byte.
- R10: A write to an address outside 0x48..0x4A and 0x50..0x5F changes no register, and such an address reads back as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_pos | input | 3 | Overhead position code: 0 payload, 1 FA1, 2 FA2, 3 EM, 4 TR |
| in_data | input | 8 | Input byte |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| out_valid | output | 1 | Output byte qualifier |
| out_sof | output | 1 | Output start of frame |
| out_data | output | 8 | Output byte |

## Verification
Two frames are walked through from a table, with all three masks set to distinct non-zero patterns. A wrong mask-to-position mapping or a crossed register therefore shows up as a different octet value. The payload bytes are chosen to equal the FA1 and FA2 input values, so that a substitution keyed on data rather than on position is caught. A run of further frames drives the trace index across its wrap. This separates a modulo-16 counter from a saturating or off-by-one counter. A mask written between the FA1 and FA2 octets of one frame tells frame-boundary sampling apart from immediate application.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
   localparam int OCTET_W = 8;

   typedef enum logic [2:0] {
      OH_PAYLOAD = 3'd0,
      OH_FA1     = 3'd1,
      OH_FA2     = 3'd2,
      OH_EM      = 3'd3,
      OH_TR      = 3'd4
   } oh_pos_e;

   typedef struct packed {
      logic [OCTET_W-1:0] fa1;
      logic [OCTET_W-1:0] fa2;
      logic [OCTET_W-1:0] em;
   } oh_masks_t;
endpackage

// File: rtl/e3oh_regfile.sv
module e3oh_regfile
   import e3oh_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                TRACE_DEPTH = 16,
   parameter logic [ADDR_W-1:0] MASK_BASE   = 'h48,
   parameter logic [ADDR_W-1:0] TRACE_BASE  = 'h50
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   we,
   input  logic [ADDR_W-1:0]                      addr,
   input  logic [OCTET_W-1:0]                     wdata,
   output logic [OCTET_W-1:0]                     rdata,
   output oh_masks_t                              masks,
   output logic [TRACE_DEPTH-1:0][OCTET_W-1:0]    trace
);
   localparam int IDX_W = $clog2(TRACE_DEPTH);

   generate
      if (ADDR_W < IDX_W + 1) begin : g_bad_aw
         $error("e3oh_regfile: ADDR_W too small for the trace store");
      end
   endgenerate

   logic [ADDR_W-1:0] tr_off;
   logic              tr_hit;
   logic              hit_fa1, hit_fa2, hit_em;
   logic [OCTET_W-1:0] rd_mux;

   assign tr_off  = addr - TRACE_BASE;
   assign tr_hit  = tr_off < ADDR_W'(TRACE_DEPTH);
   assign hit_fa1 = addr == MASK_BASE;
   assign hit_fa2 = addr == MASK_BASE + ADDR_W'(1);
   assign hit_em  = addr == MASK_BASE + ADDR_W'(2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         masks <= '0;
      end else if (we) begin
         if (hit_fa1) masks.fa1 <= wdata;
         if (hit_fa2) masks.fa2 <= wdata;
         if (hit_em)  masks.em  <= wdata;
      end
   end

   generate
      for (genvar k = 0; k < TRACE_DEPTH; k++) begin : g_trace
         always_ff @(posedge clk) begin
            if (!rst_n)
               trace[k] <= '0;
            else if (we && tr_hit && tr_off[IDX_W-1:0] == IDX_W'(k))
               trace[k] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (hit_fa1)     rd_mux = masks.fa1;
      else if (hit_fa2) rd_mux = masks.fa2;
      else if (hit_em)  rd_mux = masks.em;
      else if (tr_hit)  rd_mux = trace[tr_off[IDX_W-1:0]];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_mux;
   end

   AST_FA1_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hit_fa1) |=> masks.fa1 == $past(wdata)); // R5
   AST_EM_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hit_em) |=> masks.em == $past(wdata)); // R5
   AST_MASKS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(masks)); // R10
endmodule

// File: rtl/e3oh_mframe.sv
module e3oh_mframe
   import e3oh_pkg::*;
#(
   parameter int TRACE_DEPTH = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                frame_start,
   input  oh_masks_t                           masks_live,
   input  logic [TRACE_DEPTH-1:0][OCTET_W-1:0] trace,
   output oh_masks_t                           masks_eff,
   output logic [OCTET_W-1:0]                  tr_eff
);
   localparam int CNT_W = $clog2(TRACE_DEPTH);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRACE_DEPTH - 1);

   generate
      if (TRACE_DEPTH < 2 || (1 << CNT_W) != TRACE_DEPTH) begin : g_bad_depth
         $error("e3oh_mframe: TRACE_DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [CNT_W-1:0]   mf_cnt;
   oh_masks_t          sh_masks;
   logic [OCTET_W-1:0] sh_tr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mf_cnt   <= '0;
         sh_masks <= '0;
         sh_tr    <= '0;
      end else if (frame_start) begin
         mf_cnt   <= mf_cnt + CNT_W'(1);
         sh_masks <= masks_live;
         sh_tr    <= trace[mf_cnt];
      end
   end

   assign masks_eff = frame_start ? masks_live    : sh_masks;
   assign tr_eff    = frame_start ? trace[mf_cnt] : sh_tr;

   AST_MF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && mf_cnt == CNT_LAST) |=> mf_cnt == '0); // R7
   AST_MF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(mf_cnt)); // R7
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(sh_masks)); // R9
endmodule

// File: rtl/e3oh_datapath.sv
module e3oh_datapath
   import e3oh_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_sof,
   input  oh_pos_e            in_pos,
   input  logic [OCTET_W-1:0] in_data,
   input  oh_masks_t          masks_eff,
   input  logic [OCTET_W-1:0] tr_eff,
   output logic               out_valid,
   output logic               out_sof,
   output logic [OCTET_W-1:0] out_data
);
   logic [OCTET_W-1:0] nxt;

   always_comb begin
      case (in_pos)
         OH_FA1:  nxt = in_data ^ masks_eff.fa1;
         OH_FA2:  nxt = in_data ^ masks_eff.fa2;
         OH_EM:   nxt = in_data ^ masks_eff.em;
         OH_TR:   nxt = tr_eff;
         default: nxt = in_data;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_sof   <= in_valid & in_sof;
         out_data  <= nxt;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_sof); // R8
   AST_PAYLOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_pos == OH_PAYLOAD) |=> out_data == $past(in_data)); // R8
endmodule

// File: rtl/e3_oh_inserter.sv
module e3_oh_inserter
   import e3oh_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                TRACE_DEPTH = 16,
   parameter logic [ADDR_W-1:0] MASK_BASE   = 'h48,
   parameter logic [ADDR_W-1:0] TRACE_BASE  = 'h50
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_sof,
   input  logic [2:0]         in_pos,
   input  logic [7:0]         in_data,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               out_valid,
   output logic               out_sof,
   output logic [7:0]         out_data
);
   oh_masks_t                           masks_live, masks_eff;
   logic [TRACE_DEPTH-1:0][OCTET_W-1:0] trace;
   logic [OCTET_W-1:0]                  tr_eff;
   logic                                frame_start;

   assign frame_start = in_valid & in_sof;

   e3oh_regfile #(
      .ADDR_W(ADDR_W), .TRACE_DEPTH(TRACE_DEPTH),
      .MASK_BASE(MASK_BASE), .TRACE_BASE(TRACE_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .masks(masks_live), .trace(trace)
   );

   e3oh_mframe #(.TRACE_DEPTH(TRACE_DEPTH)) u_mframe (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .masks_live(masks_live), .trace(trace),
      .masks_eff(masks_eff), .tr_eff(tr_eff)
   );

   e3oh_datapath u_dp (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_pos(oh_pos_e'(in_pos)), .in_data(in_data),
      .masks_eff(masks_eff), .tr_eff(tr_eff),
      .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
   );

   AST_SOF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid); // R8
endmodule

// File: tb/e3_oh_inserter_test.sv
module e3_oh_inserter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_sof = 1'b0;
   logic [2:0] in_pos = 3'd0;
   logic [7:0] in_data = 8'h00;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
   logic [7:0] reg_rdata, out_data;
   logic       out_valid, out_sof;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [7:0] m_fa1, m_fa2, m_em;

   always #4 clk = ~clk;

   e3_oh_inserter uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_pos(in_pos), .in_data(in_data), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
   );

   // {pos[3], sof, din[8], expected[8]}; masks FA1=0F FA2=F0 EM=81, trace k = 30+k
   localparam logic [19:0] VEC [12] = '{
      {3'd1, 1'b1, 8'hF6, 8'hF9}, {3'd2, 1'b0, 8'h28, 8'hD8},
      {3'd3, 1'b0, 8'h5A, 8'hDB}, {3'd4, 1'b0, 8'h00, 8'h30},
      {3'd0, 1'b0, 8'h12, 8'h12}, {3'd0, 1'b0, 8'hA5, 8'hA5},
      {3'd1, 1'b1, 8'hF6, 8'hF9}, {3'd2, 1'b0, 8'h28, 8'hD8},
      {3'd3, 1'b0, 8'h00, 8'h81}, {3'd4, 1'b0, 8'hFF, 8'h31},
      {3'd0, 1'b0, 8'hF6, 8'hF6}, {3'd0, 1'b0, 8'h28, 8'h28}
   };

   task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      in_valid = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      in_valid = 1'b0; reg_addr = a;
      @(posedge clk); #1;
      chk(req, {1'b0, reg_rdata}, {1'b0, exp});
   endtask

   task automatic send(input logic [2:0] p, input logic s, input logic [7:0] d,
                       input logic [7:0] exp, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_sof = s; in_pos = p; in_data = d;
      @(posedge clk); #1;
      chk(req, {out_valid, out_data}, {1'b1, exp});
   endtask

   task automatic frame(input int f, input string req);
      send(3'd1, 1'b1, 8'hC3, 8'hC3 ^ m_fa1, req);
      send(3'd2, 1'b0, 8'h28, 8'h28 ^ m_fa2, req);
      send(3'd3, 1'b0, 8'h66, 8'h66 ^ m_em, req);
      send(3'd4, 1'b0, 8'h00, 8'h30 + 8'(f % 16), req);
      send(3'd0, 1'b0, 8'h77, 8'h77, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 out_valid", {out_sof, 7'd0, out_valid}, 9'd0);
      rd(8'h48, 8'h00, "R1 fa1 mask");
      rd(8'h49, 8'h00, "R1 fa2 mask");
      rd(8'h4A, 8'h00, "R1 em mask");
      rd(8'h50, 8'h00, "R1 trace0");

      m_fa1 = 8'h0F; m_fa2 = 8'hF0; m_em = 8'h81;
      wr(8'h48, m_fa1); wr(8'h49, m_fa2); wr(8'h4A, m_em);
      for (int k = 0; k < 16; k++) wr(8'h50 + 8'(k), 8'h30 + 8'(k));
      rd(8'h49, 8'hF0, "R5 fa2 readback");
      rd(8'h4A, 8'h81, "R5 em readback");
      rd(8'h5F, 8'h3F, "R6 trace15 readback");
      rd(8'h53, 8'h33, "R6 trace3 readback");

      // table walk: frames 0 and 1
      for (int i = 0; i < 12; i++) begin
         string tag;
         case (VEC[i][19:17])
            3'd1: tag = "R2 fa1";
            3'd2: tag = "R3 fa2";
            3'd3: tag = "R4 em";
            3'd4: tag = "R7 trace";
            default: tag = "R8 payload";
         endcase
         send(VEC[i][19:17], VEC[i][16], VEC[i][15:8], VEC[i][7:0], tag);
      end

      // frames 2..16: frame 16 takes entry 0 again
      for (int f = 2; f <= 16; f++) frame(f, "R7 multiframe");

      // frame 17: FA2 mask changed mid-frame
      send(3'd1, 1'b1, 8'hF6, 8'hF9, "R2 fa1 f17");
      wr(8'h49, 8'h3C);
      chk("R8 idle valid", {8'd0, out_valid}, 9'd0);
      rd(8'h49, 8'h3C, "R5 fa2 new value");
      send(3'd2, 1'b0, 8'h28, 8'hD8, "R9 old mask kept");
      send(3'd3, 1'b0, 8'h5A, 8'hDB, "R4 em f17");
      send(3'd4, 1'b0, 8'h00, 8'h31, "R7 trace f17");
      m_fa2 = 8'h3C;
      frame(18, "R9 new mask applied");

      // unmapped addresses
      wr(8'h47, 8'hEE);
      wr(8'h60, 8'hEE);
      rd(8'h47, 8'h00, "R10 read 0x47");
      rd(8'h60, 8'h00, "R10 read 0x60");
      rd(8'h48, 8'h0F, "R10 fa1 intact");
      rd(8'h50, 8'h30, "R10 trace0 intact");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule